// File: doc/BRIEF.md
# Programmable priority interrupt controller

This block gathers eight interrupt request lines, records their rising edges in a request register and holds back masked levels with a mask register. A fixed priority resolver picks the highest pending level that is not masked. That level only raises the interrupt output when it outranks every level already in service. When the host pulses the acknowledge strobe, the winning level moves into the in-service register and a vector byte is returned one cycle later. The vector byte is the programmed base with the level number in its low three bits.

Software reaches the block through a command address and a data address. A command byte with bit 4 set starts an initialization sequence. The data writes that follow supply the vector base, then a cascade word if one is expected, then a mode word if one is expected. After that sequence, data writes load the mask. Command bytes also provide two end-of-interrupt forms and select which register a command-address read returns. The mode word can enable automatic end-of-interrupt. A request that vanishes between the interrupt output and the acknowledge strobe is answered with a level-7 vector and is not recorded as in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers read 0, int_o is low and a command-address read returns the request register.
- R2: A command write with bit 4 set (for example 0x11) starts initialization. It clears the mask and the in-service register and sets command-address reads back to the request register. Command bit 1 set means no cascade word follows, and command bit 0 set means a mode word follows. The next data writes are taken in this order: vector base, cascade word (if expected), mode word (if expected).
- R3: Each acknowledge pulse on inta_i gives vec_vld_o high for one cycle, one cycle later. vec_o then holds bits 7:3 of the base with the granted level in bits 2:0. A granted level sets its in-service bit unless auto-EOI is on.
- R4: Bit 1 of the mode word enables auto-EOI. With auto-EOI on, an acknowledge leaves the in-service register unchanged.
- R5: Outside initialization, a data write loads the 8-bit mask (bit n masks input n), and a data-address read returns the mask.
- R6: A command byte 0x60+n (n in 0..7) clears in-service bit n only.
- R7: A command byte 0x20 clears the highest-priority (lowest-numbered) set in-service bit.
- R8: Command byte 0x0A selects the request register and 0x0B selects the in-service register for command-address reads. The selection persists across other writes.
- R9: Priority is fixed, with input 0 highest. int_o is high only when an unmasked pending level exists and no in-service level is equal or higher in priority. Masked requests never raise int_o.
- R10: A synchronised rising edge on irq_i[n] sets request bit n. The bit clears when the input falls or when level n is acknowledged.
- R11: An acknowledge while int_o is low returns the base with level 7 and changes neither the in-service nor the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Interrupt request lines, asynchronous |
| wr_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 1 | 0 selects the command address, 1 the data address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| int_o | output | 1 | Interrupt output |
| vec_o | output | 8 | Vector byte for the last acknowledge |
| vec_vld_o | output | 1 | vec_o valid, one cycle after inta_i |

## Verification
The assertions check on every cycle that each acknowledge yields a valid vector the next cycle. They also check that an unserved acknowledge returns level 7 without touching the in-service register, that auto-EOI leaves it untouched, that int_o only rises with an unmasked pending request, and that a request bit never outlives its input level. Only the bench scenarios can show the priority order against in-service levels, the init sequence length under different command bits, the two end-of-interrupt forms, and the persistence of the read selection.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    INIT_IDLE,
    INIT_BASE,
    INIT_CASC,
    INIT_MODE
  } init_st_e;

  localparam int unsigned DW = 8;
  localparam int unsigned START_BIT = 4;
  localparam logic [2:0] OP_NS_EOI = 3'b001;
  localparam logic [2:0] OP_SP_EOI = 3'b011;
endpackage

// File: rtl/irqc_req.sv
module irqc_req #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] s0_q, s1_q, prev_q, irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q   <= '0;
      s1_q   <= '0;
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      s0_q   <= irq_i;
      s1_q   <= s0_q;
      prev_q <= s1_q;
      // set on rise, drop when level falls or when acknowledged
      irr_q  <= (irr_q | (s1_q & ~prev_q)) & s1_q & ~ack_clr_i;
    end
  end

  assign irr_o = irr_q;

  a_r10_irr_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_q & ~prev_q) == '0);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  output logic [LW-1:0] win_o,
  output logic [LW-1:0] top_o,
  output logic          isr_any_o,
  output logic          grant_o
);
  always_comb begin
    win_o = '0;
    top_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) win_o = LW'(i);
      if (isr_i[i])  top_o = LW'(i);
    end
  end

  assign isr_any_o = |isr_i;
  assign grant_o   = (|pend_i) && (!isr_any_o || (win_o < top_o));

  a_r9_grant_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (pend_i[win_o] && !isr_i[win_o]));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          isr_any_i,
  input  logic [LW-1:0] top_i,
  output logic [N-1:0]  imr_o,
  output logic [DW-1:0] base_o,
  output logic          aeoi_o,
  output logic          sel_isr_o,
  output logic          init_o,
  output logic [N-1:0]  eoi_clr_o
);
  init_st_e     st_q;
  logic [N-1:0] imr_q;
  logic [DW-1:0] base_q;
  logic         aeoi_q, sel_q, need_casc_q, need_mode_q;
  logic         cmd_wr, dat_wr, init_start, sel_wr;

  assign cmd_wr     = wr_i && !addr_i;
  assign dat_wr     = wr_i && addr_i;
  assign init_start = cmd_wr && wdata_i[START_BIT];
  assign sel_wr     = cmd_wr && (wdata_i[4:3] == 2'b01) && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= INIT_IDLE;
      imr_q       <= '1;
      base_q      <= '0;
      aeoi_q      <= 1'b0;
      sel_q       <= 1'b0;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
    end else if (init_start) begin
      st_q        <= INIT_BASE;
      need_casc_q <= !wdata_i[1];
      need_mode_q <= wdata_i[0];
      imr_q       <= '0;
      sel_q       <= 1'b0;
      aeoi_q      <= 1'b0;
    end else if (sel_wr) begin
      sel_q <= wdata_i[0];
    end else if (dat_wr) begin
      case (st_q)
        INIT_IDLE: imr_q <= wdata_i[N-1:0];
        INIT_BASE: begin
          base_q <= wdata_i;
          st_q   <= need_casc_q ? INIT_CASC : (need_mode_q ? INIT_MODE : INIT_IDLE);
        end
        INIT_CASC: st_q <= need_mode_q ? INIT_MODE : INIT_IDLE;
        default: begin
          aeoi_q <= wdata_i[1];
          st_q   <= INIT_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    eoi_clr_o = '0;
    if (cmd_wr && (wdata_i[4:3] == 2'b00)) begin
      if (wdata_i[7:5] == OP_SP_EOI) eoi_clr_o[wdata_i[LW-1:0]] = 1'b1;
      else if (wdata_i[7:5] == OP_NS_EOI && isr_any_i) eoi_clr_o[top_i] = 1'b1;
    end
  end

  assign imr_o     = imr_q;
  assign base_o    = base_q;
  assign aeoi_o    = aeoi_q;
  assign sel_isr_o = sel_q;
  assign init_o    = init_start;

  a_r5_imr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && st_q == INIT_IDLE && !init_start) |=> imr_q == $past(wdata_i[N-1:0]));
  a_r2_init_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_start |=> (imr_q == '0 && st_q == INIT_BASE && !sel_q));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import irqc_pkg::*; #(
  parameter int unsigned N  = 8,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          inta_i,
  output logic          int_o,
  output logic [DW-1:0] vec_o,
  output logic          vec_vld_o
);
  logic [N-1:0]  irr, imr, isr_q, eoi_clr, ack_clr, win_oh, pend;
  logic [LW-1:0] win, top;
  logic [DW-1:0] base, vec_q;
  logic          isr_any, grant, aeoi, sel_isr, init, ack_real, vld_q;

  assign pend     = irr & ~imr;
  assign ack_real = inta_i && grant;
  assign win_oh   = {{(N-1){1'b0}}, 1'b1} << win;
  assign ack_clr  = ack_real ? win_oh : '0;

  irqc_req #(.N(N)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ack_clr_i(ack_clr), .irr_o(irr)
  );

  irqc_prio #(.N(N), .LW(LW)) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .isr_i(isr_q),
    .win_o(win), .top_o(top), .isr_any_o(isr_any), .grant_o(grant)
  );

  irqc_regs #(.N(N), .LW(LW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .isr_any_i(isr_any), .top_i(top), .imr_o(imr), .base_o(base), .aeoi_o(aeoi),
    .sel_isr_o(sel_isr), .init_o(init), .eoi_clr_o(eoi_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (init) isr_q <= '0;
      else      isr_q <= (isr_q & ~eoi_clr) | ((ack_real && !aeoi) ? win_oh : '0);
      vld_q <= inta_i;
      if (inta_i) vec_q <= {base[DW-1:LW], ack_real ? win : {LW{1'b1}}};
    end
  end

  assign int_o     = grant;
  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;
  assign rdata_o   = addr_i ? DW'(imr) : DW'(sel_isr ? isr_q : irr);

  a_r3_vld_follows_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_vld_o);
  a_r11_spur_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |=> (vec_o[LW-1:0] == {LW{1'b1}}));
  a_r11_spur_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o && !wr_i) |=> (isr_q == $past(isr_q)));
  a_r4_aeoi_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && aeoi && !wr_i) |=> (isr_q == $past(isr_q)));
  a_r9_int_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr) != '0));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq = '0, wdata = '0, rdata, vec;
  logic       wr = 1'b0, addr = 1'b0, inta = 1'b0, int_w, vld;
  int         checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P / 2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .inta_i(inta), .int_o(int_w), .vec_o(vec), .vec_vld_o(vld)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ack(string tag, logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  // monitor: compare produced vectors against scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (vld) begin
        if (exp_q.size() == 0) chk("R3 unexpected vector", vec, 8'hxx);
        else chk(tag_q.pop_front(), vec, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    rd_reg(1'b1, d); chk("R1 mask", d, 8'hFF);
    rd_reg(1'b0, d); chk("R1 irr", d, 8'h00);
    chk("R1 int", {7'b0, int_w}, 8'h00);

    // R2 full init
    wr_reg(1'b0, 8'h11);
    wr_reg(1'b1, 8'h20);
    wr_reg(1'b1, 8'h04);
    wr_reg(1'b1, 8'h01);
    rd_reg(1'b1, d); chk("R2 mask cleared", d, 8'h00);
    // R5
    wr_reg(1'b1, 8'hF0);
    rd_reg(1'b1, d); chk("R5 mask load", d, 8'hF0);

    // R9 / R10 masked request
    @(negedge clk); irq = 8'h20;
    settle(4);
    chk("R9 masked no int", {7'b0, int_w}, 8'h00);
    rd_reg(1'b0, d); chk("R10 rise sets irr", d, 8'h20);
    irq = 8'h00;
    settle(4);
    rd_reg(1'b0, d); chk("R10 fall clears irr", d, 8'h00);

    // R9 priority and in-service
    wr_reg(1'b1, 8'h00);
    @(negedge clk); irq = 8'h0A;
    settle(4);
    chk("R9 int raised", {7'b0, int_w}, 8'h01);
    ack("R3 R9 vector lvl1", 8'h21);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, d); chk("R3 isr set", d, 8'h02);
    chk("R9 lower blocked", {7'b0, int_w}, 8'h00);
    @(negedge clk); irq = 8'h0B;
    settle(4);
    chk("R9 higher nests", {7'b0, int_w}, 8'h01);
    ack("R3 vector lvl0", 8'h20);
    rd_reg(1'b0, d); chk("R8 isr select", d, 8'h03);
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, d); chk("R7 ns eoi", d, 8'h02);
    chk("R9 still blocked", {7'b0, int_w}, 8'h00);
    wr_reg(1'b0, 8'h61);
    rd_reg(1'b0, d); chk("R6 sp eoi", d, 8'h00);
    chk("R9 lvl3 now", {7'b0, int_w}, 8'h01);
    ack("R3 vector lvl3", 8'h23);
    rd_reg(1'b0, d); chk("R8 select persists", d, 8'h08);
    wr_reg(1'b0, 8'h65);
    rd_reg(1'b0, d); chk("R6 other bit kept", d, 8'h08);
    wr_reg(1'b0, 8'h63);
    rd_reg(1'b0, d); chk("R6 sp eoi lvl3", d, 8'h00);
    wr_reg(1'b0, 8'h0A);
    rd_reg(1'b0, d); chk("R10 ack clears irr", d, 8'h00);
    irq = 8'h00;
    settle(4);

    // R11 spurious
    irq = 8'h10;
    settle(4);
    chk("R11 int before drop", {7'b0, int_w}, 8'h01);
    irq = 8'h00;
    settle(4);
    chk("R11 int after drop", {7'b0, int_w}, 8'h00);
    ack("R11 spurious vector", 8'h27);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, d); chk("R11 isr clear", d, 8'h00);
    wr_reg(1'b1, 8'hFF);
    ack("R11 masked spurious", 8'h27);

    // R4 auto-EOI, R2 select reset
    wr_reg(1'b0, 8'h11);
    wr_reg(1'b1, 8'h48);
    wr_reg(1'b1, 8'h04);
    wr_reg(1'b1, 8'h03);
    irq = 8'h40;
    settle(4);
    rd_reg(1'b0, d); chk("R2 select back to irr", d, 8'h40);
    ack("R4 vector lvl6", 8'h4E);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, d); chk("R4 isr untouched", d, 8'h00);
    irq = 8'h00;
    settle(4);

    // R2 single mode: no cascade word
    wr_reg(1'b0, 8'h13);
    wr_reg(1'b1, 8'h80);
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b1, 8'h55);
    rd_reg(1'b1, d); chk("R2 short sequence", d, 8'h55);
    irq = 8'h02;
    settle(4);
    ack("R2 R3 new base", 8'h81);
    irq = 8'h00;
    settle(4);
    chk("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule